// File: doc/BRIEF.md
# Selectable Fraction Reducer

This block takes a binary fraction that carries extra low-order bits and shortens it to a narrower kept field. The extra bits exist so that an arithmetic result can be trimmed after the calculation is done. Three trimming policies sit behind one interface, and a 2-bit selector picks one of them on each sample. Plain truncation drops the extra bits and is the cheapest. Sticky-LSB ("jamming") forces the lowest kept bit to 1 whenever any dropped bit is set. Half-up rounding adds one unit in the last kept place when the first dropped bit is 1, and is the most accurate of the three.

Each sample comes with a valid strobe. The block registers its results and presents them one cycle after the sample is taken. A carry flag reports that rounding overflowed the kept field. A second flag reports that the dropped bits were not all zero.

Top module: `frac_reducer`

## Requirements
- R1: While reset is asserted and after its release, before any valid sample, res_out, carry_out and inexact are 0.
- R2: With sel = 2'b00 (truncate), res_out equals the upper KEEP bits of frac_in and carry_out is 0.
- R3: With sel = 2'b01 (sticky), res_out equals the upper KEEP bits of frac_in with bit 0 forced to 1 when any of the lower EXTRA bits is 1, and is left unchanged otherwise. carry_out is 0.
- R4: With sel = 2'b10 (round), res_out equals the upper KEEP bits plus frac_in[EXTRA-1], taken modulo 2^KEEP.
- R5: In round mode, carry_out is 1 exactly when that addition overflows, meaning the kept bits are all ones and frac_in[EXTRA-1] is 1. res_out is then all zeros.
- R6: inexact is 1 exactly when the lower EXTRA bits of frac_in are non-zero, whatever sel is.
- R7: sel = 2'b11 behaves exactly as truncate.
- R8: Outputs update on the clock edge that samples in_valid = 1 and are visible from then on. When in_valid is 0 the outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for frac_in and sel |
| frac_in | input | KEEP+EXTRA | Fraction; the upper KEEP bits are kept and the lower EXTRA bits are dropped |
| sel | input | 2 | Policy: 00 truncate, 01 sticky, 10 round, 11 truncate |
| res_out | output | KEEP | Reduced fraction |
| carry_out | output | 1 | Round overflowed the kept field |
| inexact | output | 1 | Dropped bits were non-zero |

## Verification
The block has only one register stage, so a wrong policy decode or a wrong sticky or round bit shows up on res_out in the first cycle after the sample. Corrupted hold logic shows up as outputs that change on samples where in_valid is 0, so the bench checks the outputs again after idle cycles. The wrap from all-ones to zero is the only way carry_out can assert, and it is driven directly.

// File: rtl/frac_reducer.sv
module frac_reducer #(
  parameter int KEEP  = 3,
  parameter int EXTRA = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [KEEP+EXTRA-1:0] frac_in,
  input  logic [1:0]            sel,
  output logic [KEEP-1:0]       res_out,
  output logic                  carry_out,
  output logic                  inexact
);
  localparam int W = KEEP + EXTRA;

  logic [KEEP-1:0] kept;
  logic [EXTRA-1:0] lost;
  logic             any_lost;
  logic [KEEP:0]    rounded;
  logic [KEEP-1:0]  nxt_res;
  logic             nxt_cy;

  assign kept     = frac_in[W-1:EXTRA];
  assign lost     = frac_in[EXTRA-1:0];
  assign any_lost = |lost;
  assign rounded  = {1'b0, kept} + {{KEEP{1'b0}}, lost[EXTRA-1]};

  always_comb begin
    nxt_res = kept;
    nxt_cy  = 1'b0;
    case (sel)
      2'b01: nxt_res = {kept[KEEP-1:1], kept[0] | any_lost};
      2'b10: begin
        nxt_res = rounded[KEEP-1:0];
        nxt_cy  = rounded[KEEP];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out   <= '0;
      carry_out <= 1'b0;
      inexact   <= 1'b0;
    end else if (in_valid) begin
      res_out   <= nxt_res;
      carry_out <= nxt_cy;
      inexact   <= any_lost;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_out) && $stable(carry_out) && $stable(inexact));
  a_r5_carry_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> res_out == '0);
  a_r6_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> inexact == ($past(frac_in[EXTRA-1:0]) != '0));
  a_r2_trunc_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sel != 2'b10 |=> !carry_out);
  a_r3_sticky_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sel == 2'b01 && frac_in[EXTRA-1:0] != '0 |=> res_out[0]);
endmodule

// File: tb/frac_reducer_test.sv
module frac_reducer_test;
  localparam int KEEP = 3, EXTRA = 3, W = KEEP + EXTRA;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] frac_in = '0;
  logic [1:0] sel = '0;
  logic [KEEP-1:0] res_out;
  logic carry_out, inexact;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  frac_reducer #(.KEEP(KEEP), .EXTRA(EXTRA)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frac_in(frac_in),
    .sel(sel), .res_out(res_out), .carry_out(carry_out), .inexact(inexact));

  function automatic logic [KEEP+1:0] model(input logic [W-1:0] f, input logic [1:0] s);
    logic [KEEP-1:0] k = f[W-1:EXTRA];
    logic lo = |f[EXTRA-1:0];
    int sum;
    case (s)
      2'b01: return {1'b0, k | {{(KEEP-1){1'b0}}, lo}, lo};
      2'b10: begin
        sum = int'(k) + int'(f[EXTRA-1]);
        return {sum[KEEP], sum[KEEP-1:0], lo};
      end
      default: return {1'b0, k, lo};
    endcase
  endfunction

  task automatic expect_out(input logic [KEEP+1:0] e, input string req);
    checks++;
    if ({carry_out, res_out, inexact} !== e) begin
      failures++;
      $display("FAIL %s got cy=%0b res=%0b inx=%0b exp cy=%0b res=%0b inx=%0b", req,
               carry_out, res_out, inexact, e[KEEP+1], e[KEEP:1], e[0]);
    end
  endtask

  task automatic apply(input logic [W-1:0] f, input logic [1:0] s, input string req);
    @(negedge clk); frac_in = f; sel = s; in_valid = 1;
    @(negedge clk); in_valid = 0;
    expect_out(model(f, s), req);
  endtask

  initial begin
    #200000; failures++; $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures); $finish;
  end

  initial begin
    logic [KEEP+1:0] last;
    repeat (3) @(negedge clk);
    expect_out('0, "R1 reset");
    rst_n = 1;
    @(negedge clk); expect_out('0, "R1 after release");
    apply(6'b001110, 2'b00, "R2 truncate");
    apply(6'b011000, 2'b01, "R3 sticky exact");
    apply(6'b010010, 2'b01, "R3 sticky set lsb");
    apply(6'b011100, 2'b10, "R4 round up");
    apply(6'b011010, 2'b10, "R4 round down");
    apply(6'b111100, 2'b10, "R5 carry wrap");
    apply(6'b111011, 2'b10, "R5 no carry");
    apply(6'b101000, 2'b00, "R6 exact");
    apply(6'b101001, 2'b11, "R7 mode3 truncate");
    apply(6'b111111, 2'b11, "R7 mode3 no round");
    last = model(6'b111111, 2'b11);
    @(negedge clk); frac_in = 6'b000100; sel = 2'b10;
    repeat (3) @(negedge clk);
    expect_out(last, "R8 hold when idle");
    void'($urandom(32'd1234));
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] f = W'($urandom);
      logic [1:0] s = 2'($urandom);
      apply(f, s, "R2-R7 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule